// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an idle-high asynchronous serial line into parallel characters. A falling edge on the line starts a frame. The receiver then samples the data bits, the optional parity bit and the first stop bit at a rate set by an oversampling divide select, removes the framing, and moves the character into a receive data register. Flags report whether a character is waiting, whether its parity or stop bit was wrong, and whether a later character was lost because the waiting one had not been read.

The 3-bit format code has the same meaning as on the matching transmitter, so both ends of a link agree on the data width, the parity and the stop-bit count. A carrier-present input gates the whole receiver: while the carrier is absent, the receiver stays in reset and a sticky carrier-lost flag is set.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_data is 0x00 and data_ready, parity_err, framing_err, overrun and carrier_lost are all 0.
- R2: fmt_code selects the character format as follows (data bits, parity, stop bits): 0 = 7, even, 2; 1 = 7, odd, 2; 2 = 7, even, 1; 3 = 7, odd, 1; 4 = 8, none, 2; 5 = 8, none, 1; 6 = 8, even, 1; 7 = 8, odd, 1.
- R3: With div16_sel = 1, a bit lasts 16 clocks. A low level on the line is re-checked 8 clocks after it is first seen. If the line is high again at that point, the receiver returns to idle and delivers nothing.
- R4: With div16_sel = 0, a bit lasts one clock and the line is sampled on every clock after the start bit.
- R5: Data bits arrive least significant first. In 7-bit formats, bit 7 of rx_data is 0.
- R6: parity_err is set for a delivered character whose received parity bit does not give the selected even or odd sum over the data bits and the parity bit. It is 0 for formats without parity.
- R7: framing_err is set for a delivered character whose first stop bit was sampled low. The data bits are still delivered. The receiver waits for the line to go high before it looks for the next start bit.
- R8: data_ready goes to 1 when a character is moved into rx_data. A one-cycle rd_strobe clears it.
- R9: If a frame completes while data_ready is 1 and no rd_strobe is present, overrun is set, rx_data keeps the unread character and the new character is discarded. rd_strobe clears overrun.
- R10: While carrier_ok is 0, the receiver is held in reset, data_ready and overrun are 0, and carrier_lost is 1. carrier_lost stays set until an rd_strobe arrives while carrier_ok is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| carrier_ok | input | 1 | Carrier present; 0 holds the receiver in reset |
| div16_sel | input | 1 | 1 = 16 clocks per bit, 0 = 1 clock per bit |
| fmt_code | input | 3 | Character format code (see R2) |
| rd_strobe | input | 1 | One-cycle read of the receive data register |
| rx_data | output | 8 | Receive data register |
| data_ready | output | 1 | A character is waiting |
| parity_err | output | 1 | Parity error on the last delivered character |
| framing_err | output | 1 | Stop-bit error on the last delivered character |
| overrun | output | 1 | A character was lost while one was unread |
| carrier_lost | output | 1 | Sticky carrier-loss indication |

## Verification
The hardest case to reach is the overrun, because it depends on two whole frames arriving with no read in between. The bench sends one frame, sends a second one without pulsing rd_strobe, and then checks that the first byte is still held. The false-start filter is reached by holding the line low for less than half a bit. The resynchronisation after a framing error is reached by sending a frame with a low stop bit followed directly by a good frame.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BREAK
   } rx_state_e;

   typedef struct packed {
      logic eight;     // 8 data bits when set, 7 otherwise
      logic par_en;    // a parity bit follows the data
      logic par_odd;   // odd parity when set
      logic two_stop;  // two stop bits on the line
   } fmt_t;

   function automatic fmt_t decode_fmt(input logic [2:0] code);
      fmt_t f;
      case (code)
         3'd0:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
         3'd1:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
         3'd2:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
         3'd3:    f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
         3'd4:    f = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
         3'd5:    f = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
         3'd6:    f = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
         default: f = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/rxa_sync.sv
module rxa_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("rxa_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= {STAGES{RST_VAL}};
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end

endmodule

// File: rtl/rxa_frame.sv
module rxa_frame
   import rxa_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              line,
   input  logic              div16,
   input  fmt_t              fmt,
   output logic              done,
   output logic [CHAR_W-1:0] data,
   output logic              perr,
   output logic              ferr
);

   localparam int CW   = $clog2(OVERSAMPLE);
   localparam int HALF = OVERSAMPLE / 2;
   localparam int IW   = $clog2(CHAR_W);

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     idx;
   logic [CHAR_W-1:0] shreg;
   logic              par_acc;
   logic              par_bad;

   logic              tick;
   logic [IW-1:0]     last_idx;

   // One sample per bit: every clock in divide-by-1, at the bit centre otherwise.
   assign tick     = !div16 || (cnt == CW'(OVERSAMPLE - 1));
   assign last_idx = fmt.eight ? IW'(CHAR_W - 1) : IW'(CHAR_W - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         par_bad <= 1'b0;
         done    <= 1'b0;
         data    <= '0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
      end else if (srst) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         par_acc <= 1'b0;
         par_bad <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               cnt     <= '0;
               idx     <= '0;
               par_acc <= 1'b0;
               par_bad <= 1'b0;
               if (!line) state <= div16 ? ST_START : ST_DATA;
            end
            ST_START: begin
               cnt <= cnt + 1'b1;
               if (cnt == CW'(HALF - 1)) begin
                  cnt   <= '0;
                  state <= line ? ST_IDLE : ST_DATA;
               end
            end
            ST_DATA: begin
               cnt <= cnt + 1'b1;
               if (tick) begin
                  shreg   <= {line, shreg[CHAR_W-1:1]};
                  par_acc <= par_acc ^ line;
                  idx     <= idx + 1'b1;
                  if (idx == last_idx) state <= fmt.par_en ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR: begin
               cnt <= cnt + 1'b1;
               if (tick) begin
                  par_bad <= par_acc ^ line ^ fmt.par_odd;
                  state   <= ST_STOP;
               end
            end
            ST_STOP: begin
               cnt <= cnt + 1'b1;
               if (tick) begin
                  done  <= 1'b1;
                  data  <= fmt.eight ? shreg : {1'b0, shreg[CHAR_W-1:1]};
                  perr  <= par_bad;
                  ferr  <= !line;
                  state <= line ? ST_IDLE : ST_BREAK;
               end
            end
            ST_BREAK: begin
               if (line) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rxa_hold.sv
module rxa_hold
   import rxa_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              done,
   input  logic [CHAR_W-1:0] data_in,
   input  logic              perr_in,
   input  logic              ferr_in,
   input  logic              rd,
   output logic [CHAR_W-1:0] data_q,
   output logic              ready_q,
   output logic              perr_q,
   output logic              ferr_q,
   output logic              ovr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (srst) begin
         data_q  <= '0;
         ready_q <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (done && ready_q && !rd) begin
         ovr_q <= 1'b1;          // unread byte wins, new one dropped
      end else if (done) begin
         data_q  <= data_in;
         ready_q <= 1'b1;
         perr_q  <= perr_in;
         ferr_q  <= ferr_in;
         ovr_q   <= 1'b0;
      end else if (rd) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import rxa_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_line,
   input  logic       carrier_ok,
   input  logic       div16_sel,
   input  logic [2:0] fmt_code,
   input  logic       rd_strobe,
   output logic [7:0] rx_data,
   output logic       data_ready,
   output logic       parity_err,
   output logic       framing_err,
   output logic       overrun,
   output logic       carrier_lost
);

   if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_osr
      $error("serial_rx_core: OVERSAMPLE must be a power of two of at least 4");
   end
   if (CHAR_W != 8) begin : g_bad_char
      $error("serial_rx_core: character width must be 8");
   end

   logic              line_s;
   logic              srst;
   fmt_t              fmt;
   logic              f_done;
   logic [CHAR_W-1:0] f_data;
   logic              f_perr;
   logic              f_ferr;

   assign srst = !carrier_ok;
   assign fmt  = decode_fmt(fmt_code);

   rxa_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (line_s)
   );

   rxa_frame #(
      .OVERSAMPLE (OVERSAMPLE)
   ) i_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .line  (line_s),
      .div16 (div16_sel),
      .fmt   (fmt),
      .done  (f_done),
      .data  (f_data),
      .perr  (f_perr),
      .ferr  (f_ferr)
   );

   rxa_hold i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .done    (f_done),
      .data_in (f_data),
      .perr_in (f_perr),
      .ferr_in (f_ferr),
      .rd      (rd_strobe),
      .data_q  (rx_data),
      .ready_q (data_ready),
      .perr_q  (parity_err),
      .ferr_q  (framing_err),
      .ovr_q   (overrun)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      carrier_lost <= 1'b0;
      else if (!carrier_ok)            carrier_lost <= 1'b1;
      else if (rd_strobe)              carrier_lost <= 1'b0;
   end

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       carrier_ok,
   input logic       rd_strobe,
   input logic [7:0] rx_data,
   input logic       data_ready,
   input logic       overrun,
   input logic       carrier_lost
);

   assert_keep_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !rd_strobe && carrier_ok) |=> (!carrier_ok || $stable(rx_data)));

   assert_ovr_with_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> data_ready);

   assert_read_clears_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> !overrun);

   assert_carrier_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_ok |=> (carrier_lost && !data_ready && !overrun));

   assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier_lost && !rd_strobe) |=> carrier_lost);

endmodule

bind serial_rx_core serial_rx_core_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .carrier_ok   (carrier_ok),
   .rd_strobe    (rd_strobe),
   .rx_data      (rx_data),
   .data_ready   (data_ready),
   .overrun      (overrun),
   .carrier_lost (carrier_lost)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       carrier_ok = 1'b1;
   logic       div16_sel = 1'b1;
   logic [2:0] fmt_code = 3'd5;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       data_ready;
   logic       parity_err;
   logic       framing_err;
   logic       overrun;
   logic       carrier_lost;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   serial_rx_core i_serial_rx_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_line      (rx_line),
      .carrier_ok   (carrier_ok),
      .div16_sel    (div16_sel),
      .fmt_code     (fmt_code),
      .rd_strobe    (rd_strobe),
      .rx_data      (rx_data),
      .data_ready   (data_ready),
      .parity_err   (parity_err),
      .framing_err  (framing_err),
      .overrun      (overrun),
      .carrier_lost (carrier_lost)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v, input int bt);
      rx_line = v;
      repeat (bt) @(negedge clk);
   endtask

   // Builds a frame from the format table of R2, independent of the design.
   task automatic send(input logic [7:0] b, input logic [2:0] code, input logic d16,
                       input logic flip_par, input logic bad_stop);
      int  bt;
      int  nb;
      logic pen, odd, two, p;
      bt  = d16 ? 16 : 1;
      nb  = code[2] ? 8 : 7;
      pen = !(code == 3'd4 || code == 3'd5);
      odd = (code == 3'd1 || code == 3'd3 || code == 3'd7);
      two = (code == 3'd0 || code == 3'd1 || code == 3'd4);
      fmt_code  = code;
      div16_sel = d16;
      p = odd;
      drive_bit(1'b0, bt);
      for (int i = 0; i < nb; i++) begin
         drive_bit(b[i], bt);
         p = p ^ b[i];
      end
      if (pen) drive_bit(p ^ flip_par, bt);
      drive_bit(!bad_stop, bt);
      if (two) drive_bit(1'b1, bt);
      rx_line = 1'b1;
      repeat (d16 ? 40 : 12) @(negedge clk);
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 rx_data", rx_data, 0);
      chk("R1 data_ready", data_ready, 0);
      chk("R1 parity_err", parity_err, 0);
      chk("R1 framing_err", framing_err, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 carrier_lost", carrier_lost, 0);
   endtask

   task automatic t_basic16();
      send(8'hA5, 3'd5, 1'b1, 1'b0, 1'b0);
      chk("R3 R5 8N1 data", rx_data, 8'hA5);
      chk("R8 ready set", data_ready, 1);
      chk("R7 no framing err", framing_err, 0);
      do_read();
      chk("R8 ready cleared by read", data_ready, 0);
   endtask

   task automatic t_seven();
      send(8'hD3, 3'd2, 1'b1, 1'b0, 1'b0);
      chk("R5 R2 7E1 bit7 zero", rx_data, 8'h53);
      chk("R6 7E1 good parity", parity_err, 0);
      do_read();
      send(8'h2C, 3'd0, 1'b1, 1'b0, 1'b0);
      chk("R2 7E2 data", rx_data, 8'h2C);
      do_read();
   endtask

   task automatic t_parity();
      send(8'h41, 3'd3, 1'b1, 1'b1, 1'b0);
      chk("R6 7O1 bad parity flagged", parity_err, 1);
      chk("R6 7O1 data", rx_data, 8'h41);
      do_read();
      send(8'hF0, 3'd7, 1'b1, 1'b0, 1'b0);
      chk("R6 8O1 good parity", parity_err, 0);
      chk("R6 8O1 data", rx_data, 8'hF0);
      do_read();
      send(8'h81, 3'd6, 1'b1, 1'b1, 1'b0);
      chk("R6 8E1 bad parity flagged", parity_err, 1);
      do_read();
   endtask

   task automatic t_framing();
      send(8'h5A, 3'd5, 1'b1, 1'b0, 1'b1);
      chk("R7 framing err set", framing_err, 1);
      chk("R7 data kept", rx_data, 8'h5A);
      do_read();
      send(8'h3C, 3'd5, 1'b1, 1'b0, 1'b0);
      chk("R7 resync data", rx_data, 8'h3C);
      chk("R7 framing err clear", framing_err, 0);
      do_read();
   endtask

   task automatic t_false_start();
      div16_sel = 1'b1;
      rx_line = 1'b0;
      repeat (4) @(negedge clk);
      rx_line = 1'b1;
      repeat (60) @(negedge clk);
      chk("R3 false start ignored", data_ready, 0);
   endtask

   task automatic t_div1();
      send(8'h96, 3'd4, 1'b0, 1'b0, 1'b0);
      chk("R4 div1 8N2 data", rx_data, 8'h96);
      chk("R4 div1 ready", data_ready, 1);
      do_read();
      send(8'h01, 3'd6, 1'b0, 1'b1, 1'b0);
      chk("R4 R6 div1 bad parity", parity_err, 1);
      chk("R4 div1 8E1 data", rx_data, 8'h01);
      do_read();
   endtask

   task automatic t_overrun();
      send(8'h11, 3'd5, 1'b1, 1'b0, 1'b0);
      send(8'h22, 3'd5, 1'b1, 1'b0, 1'b0);
      chk("R9 overrun set", overrun, 1);
      chk("R9 old byte kept", rx_data, 8'h11);
      do_read();
      chk("R9 overrun cleared", overrun, 0);
      chk("R9 ready cleared", data_ready, 0);
      send(8'h33, 3'd5, 1'b1, 1'b0, 1'b0);
      chk("R9 next byte accepted", rx_data, 8'h33);
      chk("R9 no overrun", overrun, 0);
      do_read();
   endtask

   task automatic t_carrier();
      send(8'h44, 3'd5, 1'b1, 1'b0, 1'b0);
      carrier_ok = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 carrier_lost set", carrier_lost, 1);
      chk("R10 ready cleared", data_ready, 0);
      carrier_ok = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 carrier_lost sticky", carrier_lost, 1);
      do_read();
      chk("R10 carrier_lost cleared by read", carrier_lost, 0);
      send(8'h55, 3'd5, 1'b1, 1'b0, 1'b0);
      chk("R10 receives after carrier returns", rx_data, 8'h55);
      do_read();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_basic16();
      t_seven();
      t_parity();
      t_framing();
      t_false_start();
      t_div1();
      t_overrun();
      t_carrier();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule